// File: doc/BRIEF.md
# CPU I/O Cycle Decoder

This block steers each processor I/O cycle to exactly one destination: the two internal configuration ports, the internal graphics I/O window, a programmable bridge window toward the AGP port, or the default downstream hub path. Every cycle carries a 17-bit address (bit 16 is the wrap line A16), a byte count, a read/write flag and a valid strobe. The decoder registers its verdict one clock after it accepts the cycle. The verdict holds a one-hot target select, the untranslated address, the write flag, a flag that says whether a write may be posted, and a flag that marks an access running past FFFFh.

The bridge window is set by two 4-bit page registers (base and limit). A simple write port loads them. Each nibble stands for address bits 15:12, so the window opens on a 4 KB boundary and grows in 4 KB steps. The cycle stream in and the verdict stream out both use valid/ready. An input cycle is taken on a clock edge where `cyc_valid` and `cyc_ready` are both high. `cyc_ready` is high whenever the output stage is empty or its contents are being taken on that same edge. While `dec_valid` is high and `dec_ready` is low, every `dec_*` output holds still and no new cycle is accepted.

Top module: `cpu_io_decoder`

## Requirements
- R1: After reset, `dec_valid` is 0 and `cyc_ready` is 1. The base register resets to Fh and the limit register to 0h, so the bridge window starts disabled.
- R2: Every verdict has exactly one bit set in `dec_target`. The encoding is bit 0 config ports, bit 1 graphics, bit 2 bridge, bit 3 hub.
- R3: The config ports are claimed ahead of every other target in two cases: a 4-byte access starting at 0CF8h, and any access starting in 0CFCh–0CFFh. A 1- or 2-byte access at 0CF8h through 0CFBh is decoded as an ordinary address.
- R4: When `gfx_en` is high at acceptance, starting addresses 03B0h–03BBh and 03C0h–03DFh go to graphics, ahead of the bridge window. When `gfx_en` is low they are not sent to graphics.
- R5: When base ≤ limit, a cycle goes to the bridge if {base,000h} ≤ address[15:0] ≤ {limit,FFFh}, with both ends inclusive. When base > limit, the window claims nothing.
- R6: A cycle that no other target claims goes to the hub. Any cycle with address bit 16 set goes to the hub.
- R7: `dec_addr` and `dec_write` equal the accepted `cyc_addr` and `cyc_write`, with no translation.
- R8: `dec_post_ok` is 1 only for writes whose start address is not an IDE port (01F0h–01F7h, 0170h–0177h with bit 16 clear). Reads always give 0.
- R9: `dec_wrap` is 1 exactly for a 4-byte access whose low 16 address bits are FFFDh–FFFFh, or a 2-byte access at FFFFh. The byte count `cyc_len` is 1, 2 or 4.
- R10: A cycle accepted at an edge shows with `dec_valid` high right after that edge. While `dec_valid` is high and `dec_ready` is low, the outputs hold and `cyc_ready` is 0.
- R11: A window write (`win_wr_sel` 0 = base, 1 = limit; the data is the page nibble) applies to cycles accepted on later edges. A cycle accepted on the same edge as the write is decoded with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | I/O cycle offered |
| cyc_ready | output | 1 | Decoder can take a cycle |
| cyc_addr | input | 17 | Start address, bit 16 is the wrap line |
| cyc_len | input | 3 | Byte count: 1, 2 or 4 |
| cyc_write | input | 1 | 1 = write, 0 = read |
| gfx_en | input | 1 | Internal graphics I/O decode enable |
| win_wr_en | input | 1 | Window register write strobe |
| win_wr_sel | input | 1 | 0 = base, 1 = limit |
| win_wr_data | input | 4 | Page nibble (address bits 15:12) |
| dec_valid | output | 1 | Verdict available |
| dec_ready | input | 1 | Consumer takes the verdict |
| dec_target | output | 4 | One-hot target select |
| dec_addr | output | 17 | Forwarded address |
| dec_write | output | 1 | Forwarded write flag |
| dec_post_ok | output | 1 | Write may be posted |
| dec_wrap | output | 1 | Access crosses FFFFh |

## Verification
A page register holding the wrong value shows up as a wrong target on the first cycle accepted in the affected 4 KB page. Fine-stepped sweeps across every page edge expose this on that same verdict. A lost or duplicated output valid puts the stream of verdicts out of order against the expected sequence, and this is seen on the very next handshake. Stale output data under back-pressure is caught on the cycle after the stall begins.

// File: rtl/cpu_io_dec_pkg.sv
package cpu_io_dec_pkg;

  localparam int IO_LOW_W = 16;

  typedef enum logic [3:0] {
    TGT_CFG = 4'b0001,
    TGT_GFX = 4'b0010,
    TGT_AGP = 4'b0100,
    TGT_HUB = 4'b1000
  } io_tgt_e;

  typedef struct packed {
    logic [IO_LOW_W-1:0] lo;
    logic [IO_LOW_W-1:0] hi;
  } io_span_t;

  // element [1] is the upper concatenation half
  localparam io_span_t [1:0] GFX_SPANS = {16'h03C0, 16'h03DF, 16'h03B0, 16'h03BB};
  localparam io_span_t [1:0] IDE_SPANS = {16'h01F0, 16'h01F7, 16'h0170, 16'h0177};

endpackage

// File: rtl/io_span_hit.sv
module io_span_hit
  import cpu_io_dec_pkg::*;
#(
  parameter int N = 2,
  parameter io_span_t [N-1:0] SPANS = '0
) (
  input  logic [IO_LOW_W-1:0] addr,
  output logic                hit
);

  logic [N-1:0] each;

  for (genvar i = 0; i < N; i++) begin : g_span
    assign each[i] = (addr >= SPANS[i].lo) && (addr <= SPANS[i].hi);
  end

  assign hit = |each;

endmodule

// File: rtl/io_win_regs.sv
module io_win_regs #(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [WIN_W-1:0] wr_data,
  output logic [WIN_W-1:0] base,
  output logic [WIN_W-1:0] limit,
  output logic             win_on
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base  <= '1;
      limit <= '0;
    end else if (wr_en) begin
      if (wr_sel) limit <= wr_data;
      else        base  <= wr_data;
    end
  end

  assign win_on = (base <= limit);

  p_wr_base_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel |=> base == $past(wr_data));

  p_wr_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel |=> limit == $past(wr_data));

  p_reg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base) && $stable(limit));

endmodule

// File: rtl/io_target_sel.sv
module io_target_sel
  import cpu_io_dec_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LEN_W  = 3,
  parameter int WIN_W  = 4,
  parameter logic [ADDR_W-2:0] CFG_ADDR_PORT = 16'h0CF8,
  parameter logic [ADDR_W-2:0] CFG_DATA_PORT = 16'h0CFC
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic              wr,
  input  logic              gfx_en,
  input  logic [WIN_W-1:0]  base,
  input  logic [WIN_W-1:0]  limit,
  input  logic              win_on,
  output io_tgt_e           tgt,
  output logic              post_ok,
  output logic              wrap
);

  localparam int LOW_AW   = ADDR_W - 1;
  localparam int PAGE_LSB = LOW_AW - WIN_W;
  localparam int RW       = LOW_AW + 1;
  localparam int SPAN     = 1 << LOW_AW;

  logic [LOW_AW-1:0] lo;
  logic              above;
  logic [WIN_W-1:0]  page;
  logic              cfg_hit, gfx_span, ide_span, gfx_hit, agp_hit;
  logic [RW-1:0]     reach;

  assign lo    = addr[LOW_AW-1:0];
  assign above = addr[ADDR_W-1];
  assign page  = lo[LOW_AW-1:PAGE_LSB];

  io_span_hit #(.N(2), .SPANS(GFX_SPANS)) u_gfx_span (.addr(lo), .hit(gfx_span));
  io_span_hit #(.N(2), .SPANS(IDE_SPANS)) u_ide_span (.addr(lo), .hit(ide_span));

  assign cfg_hit = !above &&
                   (((lo == CFG_ADDR_PORT) && (len == LEN_W'(4))) ||
                    (lo[LOW_AW-1:2] == CFG_DATA_PORT[LOW_AW-1:2]));
  assign gfx_hit = !above && gfx_en && gfx_span;
  assign agp_hit = !above && win_on && (page >= base) && (page <= limit);

  always_comb begin
    if (cfg_hit)      tgt = TGT_CFG;
    else if (gfx_hit) tgt = TGT_GFX;
    else if (agp_hit) tgt = TGT_AGP;
    else              tgt = TGT_HUB;
  end

  assign post_ok = wr && !(ide_span && !above);
  assign reach   = {1'b0, lo} + RW'(len);
  assign wrap    = reach > RW'(SPAN);

endmodule

// File: rtl/cpu_io_decoder.sv
module cpu_io_decoder
  import cpu_io_dec_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LEN_W  = 3,
  parameter int WIN_W  = 4,
  parameter logic [ADDR_W-2:0] CFG_ADDR_PORT = 16'h0CF8,
  parameter logic [ADDR_W-2:0] CFG_DATA_PORT = 16'h0CFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  output logic              cyc_ready,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [LEN_W-1:0]  cyc_len,
  input  logic              cyc_write,
  input  logic              gfx_en,
  input  logic              win_wr_en,
  input  logic              win_wr_sel,
  input  logic [WIN_W-1:0]  win_wr_data,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [3:0]        dec_target,
  output logic [ADDR_W-1:0] dec_addr,
  output logic              dec_write,
  output logic              dec_post_ok,
  output logic              dec_wrap
);

  localparam int LOW_AW = ADDR_W - 1;

  logic [WIN_W-1:0] base, limit;
  logic             win_on;
  io_tgt_e          tgt_d;
  logic             post_d, wrap_d;
  logic             take;

  io_win_regs #(.WIN_W(WIN_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (win_wr_en),
    .wr_sel (win_wr_sel),
    .wr_data(win_wr_data),
    .base   (base),
    .limit  (limit),
    .win_on (win_on)
  );

  io_target_sel #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .WIN_W(WIN_W),
    .CFG_ADDR_PORT(CFG_ADDR_PORT), .CFG_DATA_PORT(CFG_DATA_PORT)
  ) u_sel (
    .addr   (cyc_addr),
    .len    (cyc_len),
    .wr     (cyc_write),
    .gfx_en (gfx_en),
    .base   (base),
    .limit  (limit),
    .win_on (win_on),
    .tgt    (tgt_d),
    .post_ok(post_d),
    .wrap   (wrap_d)
  );

  assign cyc_ready = !dec_valid || dec_ready;
  assign take      = cyc_valid && cyc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_target  <= '0;
      dec_addr    <= '0;
      dec_write   <= 1'b0;
      dec_post_ok <= 1'b0;
      dec_wrap    <= 1'b0;
    end else if (take) begin
      dec_valid   <= 1'b1;
      dec_target  <= tgt_d;
      dec_addr    <= cyc_addr;
      dec_write   <= cyc_write;
      dec_post_ok <= post_d;
      dec_wrap    <= wrap_d;
    end else if (dec_ready) begin
      dec_valid   <= 1'b0;
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $onehot(dec_target));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_addr) && $stable(dec_target)
      && $stable(dec_write) && $stable(dec_post_ok) && $stable(dec_wrap));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |-> !cyc_ready);

  p_fwd_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && cyc_ready |=> dec_valid && dec_addr == $past(cyc_addr)
      && dec_write == $past(cyc_write));

  p_read_nopost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_write |-> !dec_post_ok);

  p_a16_hub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_addr[ADDR_W-1] |-> dec_target == TGT_HUB);

  p_cfg_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_addr[ADDR_W-1] &&
    dec_addr[LOW_AW-1:2] == CFG_DATA_PORT[LOW_AW-1:2] |-> dec_target == TGT_CFG);

  p_gfx_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && !gfx_en |=> dec_target != TGT_GFX);

  p_win_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && !win_on |=> dec_target != TGT_AGP);

endmodule

// File: tb/cpu_io_decoder_tb.sv
module cpu_io_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic        cyc_ready;
  logic [16:0] cyc_addr = '0;
  logic [2:0]  cyc_len = 3'd1;
  logic        cyc_write = 1'b0;
  logic        gfx_en = 1'b0;
  logic        win_wr_en = 1'b0;
  logic        win_wr_sel = 1'b0;
  logic [3:0]  win_wr_data = '0;
  logic        dec_valid;
  logic        dec_ready = 1'b1;
  logic [3:0]  dec_target;
  logic [16:0] dec_addr;
  logic        dec_write, dec_post_ok, dec_wrap;

  always #4 clk = ~clk;

  cpu_io_decoder u_dut (
    .clk(clk), .rst_n(rst_n),
    .cyc_valid(cyc_valid), .cyc_ready(cyc_ready), .cyc_addr(cyc_addr),
    .cyc_len(cyc_len), .cyc_write(cyc_write), .gfx_en(gfx_en),
    .win_wr_en(win_wr_en), .win_wr_sel(win_wr_sel), .win_wr_data(win_wr_data),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_target(dec_target),
    .dec_addr(dec_addr), .dec_write(dec_write), .dec_post_ok(dec_post_ok),
    .dec_wrap(dec_wrap)
  );

  typedef struct {
    logic [16:0] addr;
    bit          w;
    logic [3:0]  t;
    bit          p;
    bit          wr;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;
  logic [3:0]  sb = 4'hF, sl = 4'h0;
  bit          hold_pend = 0;
  logic [16:0] h_addr;
  logic [3:0]  h_tgt;
  bit          h_post, h_wrap, h_w;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [16:0] a, input logic [2:0] ln, input bit w,
                                input bit g, input logic [3:0] b, input logic [3:0] l,
                                output logic [3:0] t, output bit p, output bit wr);
    int  lo = int'(a[15:0]);
    bit  top = a[16];
    bit  cfg = !top && ((lo == 'h0CF8 && ln == 3'd4) || (lo >= 'h0CFC && lo <= 'h0CFF));
    bit  gfx = !top && g && ((lo >= 'h03B0 && lo <= 'h03BB) || (lo >= 'h03C0 && lo <= 'h03DF));
    bit  agp = !top && (b <= l) && lo >= int'(b) * 4096 && lo <= int'(l) * 4096 + 4095;
    bit  ide = !top && ((lo >= 'h01F0 && lo <= 'h01F7) || (lo >= 'h0170 && lo <= 'h0177));
    if (cfg)      t = 4'b0001;
    else if (gfx) t = 4'b0010;
    else if (agp) t = 4'b0100;
    else          t = 4'b1000;
    p  = w && !ide;
    wr = (lo + int'(ln)) > 65536;
  endfunction

  function automatic string tgt_tag(input logic [3:0] t);
    case (t)
      4'b0001: return "R3";
      4'b0010: return "R4";
      4'b0100: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input bit v, input logic [16:0] a, input logic [2:0] ln, input bit w,
                      input bit g, input bit rdy, input bit we, input bit ws,
                      input logic [3:0] wd, input string tag);
    exp_t e;
    @(negedge clk);
    if (hold_pend) begin
      chk(dec_valid === 1'b1, "R10", "valid held", 32'(dec_valid), 1);
      chk(dec_addr === h_addr && dec_target === h_tgt && dec_post_ok === h_post
          && dec_wrap === h_wrap && dec_write === h_w, "R10", "data held",
          32'(dec_addr), 32'(h_addr));
    end
    cyc_valid = v; cyc_addr = a; cyc_len = ln; cyc_write = w; gfx_en = g;
    dec_ready = rdy; win_wr_en = we; win_wr_sel = ws; win_wr_data = wd;
    #1;
    if (dec_valid && !dec_ready)
      chk(cyc_ready === 1'b0, "R10", "ready low while stalled", 32'(cyc_ready), 0);
    if (dec_valid && dec_ready) begin
      if (q.size() == 0) chk(1'b0, "R10", "unexpected verdict", 32'(dec_addr), 0);
      else begin
        e = q.pop_front();
        chk(dec_target === e.t, (e.tag != "") ? e.tag : tgt_tag(e.t), "target",
            32'(dec_target), 32'(e.t));
        chk(dec_addr === e.addr && dec_write === e.w, "R7", "addr/write",
            32'({dec_write, dec_addr}), 32'({e.w, e.addr}));
        chk(dec_post_ok === e.p, "R8", "post_ok", 32'(dec_post_ok), 32'(e.p));
        chk(dec_wrap === e.wr, "R9", "wrap", 32'(dec_wrap), 32'(e.wr));
      end
    end
    hold_pend = dec_valid && !dec_ready;
    h_addr = dec_addr; h_tgt = dec_target; h_post = dec_post_ok;
    h_wrap = dec_wrap; h_w = dec_write;
    if (cyc_valid && cyc_ready) begin
      e.addr = a; e.w = w; e.tag = tag;
      model(a, ln, w, g, sb, sl, e.t, e.p, e.wr);
      q.push_back(e);
    end
    if (we) begin
      if (ws) sl = wd;
      else    sb = wd;
    end
  endtask

  task automatic go(input logic [16:0] a, input logic [2:0] ln, input bit w, input bit g);
    step(1, a, ln, w, g, 1, 0, 0, 4'h0, "");
  endtask

  task automatic set_win(input logic [3:0] b, input logic [3:0] l);
    step(0, '0, 3'd1, 0, 0, 1, 1, 0, b, "");
    step(0, '0, 3'd1, 0, 0, 1, 1, 1, l, "");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 3'd1, 0, 0, 1, 0, 0, 4'h0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] lens[3] = '{3'd1, 3'd2, 3'd4};
    logic [3:0] cfgs[12] = '{4'h0, 4'h0, 4'h0, 4'hF, 4'h5, 4'h5, 4'h7, 4'h4,
                             4'hF, 4'hF, 4'hA, 4'hC};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(dec_valid === 1'b0, "R1", "dec_valid after reset", 32'(dec_valid), 0);
    chk(cyc_ready === 1'b1, "R1", "cyc_ready after reset", 32'(cyc_ready), 1);
    // R1: window disabled at reset, page 1 and page F go to hub
    step(1, 17'h01000, 3'd1, 0, 0, 1, 0, 0, 4'h0, "R1");
    step(1, 17'h0F000, 3'd1, 0, 0, 1, 0, 0, 4'h0, "R1");
    step(1, 17'h00000, 3'd1, 0, 0, 1, 0, 0, 4'h0, "R1");

    // Full sweep of the low 64K with window 1000h-3FFFh (R2..R9)
    set_win(4'h1, 4'h3);
    for (int i = 0; i < 65536; i++)
      go({1'b0, 16'(i)}, lens[i % 3], i[0] ^ i[5], ~i[1]);

    // Config port corners (R3): sub-dword at 0CF8h is not claimed
    set_win(4'h0, 4'hF);
    for (int k = 0; k < 3; k++) go(17'h00CF8, lens[k], 1, 1);
    go(17'h00CF9, 3'd4, 0, 1);
    go(17'h00CFB, 3'd1, 0, 1);
    for (int k = 0; k < 4; k++) go(17'(16'h0CFC + k), 3'd1, 1, 1);
    go(17'h00D00, 3'd1, 0, 1);

    // Graphics window edges with enable on and off (R4) under a full window
    for (int gg = 0; gg < 2; gg++) begin
      go(17'h003AF, 3'd1, 0, gg[0]); go(17'h003B0, 3'd1, 0, gg[0]);
      go(17'h003BB, 3'd1, 0, gg[0]); go(17'h003BC, 3'd1, 0, gg[0]);
      go(17'h003C0, 3'd2, 0, gg[0]); go(17'h003DF, 3'd1, 0, gg[0]);
      go(17'h003E0, 3'd1, 0, gg[0]);
    end

    // Window configurations with page edges (R5), includes base > limit
    for (int c = 0; c < 6; c++) begin
      set_win(cfgs[2*c], cfgs[2*c+1]);
      for (int p = 0; p < 256; p++) begin
        go({1'b0, 8'(p), 8'h00}, 3'd1, 1, 0);
        go({1'b0, 8'(p), 8'hFF}, 3'd2, 0, 0);
      end
    end

    // A16 and wrap (R6, R9) with a window covering all pages
    set_win(4'h0, 4'hF);
    for (int k = 0; k < 3; k++) begin
      go(17'h0FFFC, lens[k], 1, 0); go(17'h0FFFD, lens[k], 1, 0);
      go(17'h0FFFE, lens[k], 0, 0); go(17'h0FFFF, lens[k], 1, 0);
      go(17'h1FFFD, lens[k], 1, 0); go(17'h1FFFF, lens[k], 0, 0);
      go(17'h10000, lens[k], 1, 0); go(17'h10002, lens[k], 1, 0);
      go(17'h10CFC, lens[k], 1, 1); go(17'h101F0, lens[k], 1, 1);
    end

    // IDE ports never posted (R8)
    go(17'h001F0, 3'd1, 1, 0); go(17'h001F7, 3'd1, 1, 0); go(17'h001F8, 3'd1, 1, 0);
    go(17'h001EF, 3'd1, 1, 0); go(17'h00170, 3'd2, 1, 0); go(17'h00177, 3'd1, 1, 0);
    go(17'h0016F, 3'd4, 1, 0); go(17'h00178, 3'd1, 1, 0); go(17'h001F0, 3'd1, 0, 0);

    // Back-pressure (R10)
    step(1, 17'h02000, 3'd4, 1, 0, 0, 0, 0, 4'h0, "");
    for (int k = 0; k < 4; k++)
      step(1, 17'(17'h02100 + k), 3'd1, 0, 0, 0, 0, 0, 4'h0, "");
    step(1, 17'h02200, 3'd1, 0, 0, 1, 0, 0, 4'h0, "");
    step(1, 17'h02300, 3'd2, 1, 0, 0, 0, 0, 4'h0, "");
    step(0, '0, 3'd1, 0, 0, 0, 0, 0, 4'h0, "");
    idle(2);

    // Write on the same edge as an accepted cycle (R11): old value applies
    set_win(4'h2, 4'h2);
    step(1, 17'h02800, 3'd1, 0, 0, 1, 1, 0, 4'h3, "R11");
    step(1, 17'h02800, 3'd1, 0, 0, 1, 0, 0, 4'h0, "R11");
    step(1, 17'h03000, 3'd1, 0, 0, 1, 1, 1, 4'h3, "R11");
    step(1, 17'h03000, 3'd1, 0, 0, 1, 0, 0, 4'h0, "R11");
    step(1, 17'h02000, 3'd1, 0, 0, 1, 0, 0, 4'h0, "R11");

    idle(4);
    chk(q.size() == 0, "R10", "verdicts outstanding", 32'(q.size()), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule